// File: doc/BRIEF.md
# Carrier Detect Pulse Qualifier

This block decides whether a usable receive carrier is present on a frequency-shift-keyed line. An analog comparator outside the block goes high each time the filtered receive signal exceeds the carrier-detect threshold. That comparator output arrives here as a train of pulses. The block synchronises the pulse line to its own clock and counts its rising edges. It raises the carrier flag once a run of consecutive pulses is long enough. The flag stays up as long as each pulse follows the previous one within a timeout window.

The block works only in receive mode, which is when the active-low request-to-send input is high. Driving request-to-send low (transmit mode) clears the flag and the run count at once. A loss of carrier, from a timeout or from a switch to transmit, always forces a full requalification from zero.

With the default parameters at a 460.8 kHz clock, a run of four pulses is needed, which takes roughly 3.33 ms of 1200 Hz carrier or 1.82 ms of 2200 Hz carrier. The timeout is 1152 clocks, which is 2.5 ms.

Top module: `carrier_qualifier`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, carrier_ok is 0 and the run count and gap timer are cleared.
- R2: Only rising edges of the synchronised pulse input are counted. The edge is detected after SYNC_STAGES clocks, and the count updates on the following clock. carrier_ok therefore rises at the (SYNC_STAGES+1)-th rising clock edge after the input rise that completes the run.
- R3: Fewer than PULSES_NEEDED consecutive rising edges never raise carrier_ok.
- R4: Once raised, carrier_ok stays 1 while rts_n is 1 and each rising edge follows the previous one within GAP_CYCLES clocks.
- R5: If GAP_CYCLES+1 clocks pass after a counted edge with no new edge, carrier_ok falls. It is 1 after the (SYNC_STAGES+1+GAP_CYCLES)-th clock edge after the last input rise and 0 after the next clock edge.
- R6: During qualification, a gap longer than GAP_CYCLES clears the run count. An edge that arrives after the timeout starts a new run with a count of one.
- R7: A 0 on rts_n clears carrier_ok on the next clock edge and clears the run count.
- R8: After carrier_ok falls for any reason, PULSES_NEEDED new consecutive edges are needed to raise it again.
- R9: A pulse input held high is a single edge, not repeated edges.
- R10: While rts_n is 0, pulses on the input never raise carrier_ok and leave no partial count behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (460.8 kHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset, clears all state |
| cmp_pulse | input | 1 | Asynchronous amplitude comparator output |
| rts_n | input | 1 | Active-low request-to-send; 1 selects receive mode |
| carrier_ok | output | 1 | Carrier detect flag |

## Verification
The bench builds the block with PULSES_NEEDED at 4, SYNC_STAGES at 2 and GAP_CYCLES reduced to 40. The short timeout lets the bench test both sides of the gap boundary exactly: a spacing of 40 clocks keeps the flag, a spacing of 41 drops it, and the fall lands on a predicted clock edge. It also keeps every timeout scenario to a few hundred cycles. The two-stage synchroniser gives a fixed three-clock rise latency, and the bench checks it on the exact edge.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

  // bits needed to hold values 0..limit
  function automatic int bits_for(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  // a gap counter value at or above the window means the carrier is stale
  function automatic logic gap_expired(input int unsigned cnt, input int unsigned window);
    return cnt >= window;
  endfunction

  // run count after one more edge, saturating at the target
  function automatic int unsigned run_next(input int unsigned cnt, input int unsigned target);
    return (cnt >= target) ? target : cnt + 1;
  endfunction

endpackage

// File: rtl/cdq_sync_edge.sv
module cdq_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[SYNC_STAGES-1];

  assign rise = chain[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/cdq_gap_timer.sv
module cdq_gap_timer
  import cdq_pkg::*;
#(
  parameter int GAP_CYCLES = 1152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rise,
  output logic timeout
);
  localparam int GW = bits_for(GAP_CYCLES);
  localparam logic [GW-1:0] GAP_V = GW'(GAP_CYCLES);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                gap_cnt <= '0;
    else if (!rx_en || rise)   gap_cnt <= '0;
    else if (gap_cnt < GAP_V)  gap_cnt <= gap_cnt + 1'b1;

  assign timeout = gap_expired(int'(gap_cnt), GAP_CYCLES);
endmodule

// File: rtl/cdq_run_counter.sv
module cdq_run_counter
  import cdq_pkg::*;
#(
  parameter int PULSES_NEEDED = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rx_en,
  input  logic                                rise,
  input  logic                                timeout,
  output logic [bits_for(PULSES_NEEDED)-1:0]  run_cnt,
  output logic                                carrier
);
  localparam int CW = bits_for(PULSES_NEEDED);
  localparam logic [CW-1:0] LAST_V = CW'(PULSES_NEEDED - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_cnt <= '0;
      carrier <= 1'b0;
    end else if (!rx_en) begin
      run_cnt <= '0;
      carrier <= 1'b0;
    end else if (timeout) begin
      carrier <= 1'b0;
      run_cnt <= rise ? CW'(1) : '0;
    end else if (rise) begin
      run_cnt <= CW'(run_next(int'(run_cnt), PULSES_NEEDED));
      if (run_cnt >= LAST_V) carrier <= 1'b1;
    end
endmodule

// File: rtl/carrier_qualifier.sv
module carrier_qualifier
  import cdq_pkg::*;
#(
  parameter int PULSES_NEEDED = 4,
  parameter int GAP_CYCLES    = 1152,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_pulse,
  input  logic rts_n,
  output logic carrier_ok
);
  localparam int CW = bits_for(PULSES_NEEDED);

  logic          edge_seen;
  logic          timeout;
  logic          rx_en;
  logic [CW-1:0] pulse_cnt;

  assign rx_en = rts_n;

  cdq_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cmp_pulse), .rise(edge_seen)
  );

  cdq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rise(edge_seen), .timeout(timeout)
  );

  cdq_run_counter #(.PULSES_NEEDED(PULSES_NEEDED)) u_run (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rise(edge_seen),
    .timeout(timeout), .run_cnt(pulse_cnt), .carrier(carrier_ok)
  );
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker
  import cdq_pkg::*;
#(
  parameter int PULSES_NEEDED = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               rts_n,
  input logic                               carrier_ok,
  input logic                               edge_seen,
  input logic                               timeout,
  input logic [bits_for(PULSES_NEEDED)-1:0] pulse_cnt
);
  a_r7_tx_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_n |=> (!carrier_ok && pulse_cnt == '0));

  a_r2_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_ok) |-> ($past(edge_seen) && $past(rts_n)));

  a_r3_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_ok) |-> ($past(pulse_cnt) == (PULSES_NEEDED - 1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_ok && rts_n && !timeout) |=> carrier_ok);

  a_r5_timeout_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_ok && timeout) |=> !carrier_ok);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PULSES_NEEDED);
endmodule

bind carrier_qualifier cdq_checker #(.PULSES_NEEDED(PULSES_NEEDED)) u_chk (
  .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .carrier_ok(carrier_ok),
  .edge_seen(edge_seen), .timeout(timeout), .pulse_cnt(pulse_cnt)
);

// File: tb/carrier_qualifier_test.sv
`timescale 1ns/1ps
module carrier_qualifier_test;
  localparam int N   = 4;
  localparam int GAP = 40;
  localparam int SS  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_pulse = 1'b0;
  logic rts_n = 1'b1;
  logic carrier_ok;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  carrier_qualifier #(.PULSES_NEEDED(N), .GAP_CYCLES(GAP), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_pulse(cmp_pulse), .rts_n(rts_n), .carrier_ok(carrier_ok)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: carrier_ok=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one pulse, high two clocks, rise to next rise = period clocks
  task automatic pulses(input int count, input int period);
    for (int i = 0; i < count; i++) begin
      cmp_pulse = 1'b1; ticks(2);
      cmp_pulse = 1'b0; ticks(period - 2);
    end
  endtask

  task automatic clear_state();
    cmp_pulse = 1'b0; rts_n = 1'b0; ticks(4); rts_n = 1'b1; ticks(2);
  endtask

  task automatic t_reset();
    check("R1 in reset", carrier_ok, 1'b0);
    @(negedge clk); rst_n = 1'b1; ticks(3);
    check("R1 after reset", carrier_ok, 1'b0);
  endtask

  task automatic t_qualify_latency();
    clear_state();
    pulses(N - 1, 10);
    check("R3 three edges", carrier_ok, 1'b0);
    cmp_pulse = 1'b1; ticks(SS);
    check("R2 before latency", carrier_ok, 1'b0);
    ticks(1);
    check("R2 at latency", carrier_ok, 1'b1);
    cmp_pulse = 1'b0; ticks(7);
  endtask

  task automatic t_hold_boundary();
    pulses(6, GAP);
    check("R4 spacing equal to window", carrier_ok, 1'b1);
    // exact fall timing from the last rise
    cmp_pulse = 1'b1; ticks(2); cmp_pulse = 1'b0;
    ticks(SS + 1 + GAP - 2);
    check("R5 one edge before fall", carrier_ok, 1'b1);
    ticks(1);
    check("R5 fall edge", carrier_ok, 1'b0);
  endtask

  task automatic t_late_edge();
    clear_state();
    pulses(N, 10);
    check("R2 qualified", carrier_ok, 1'b1);
    pulses(1, GAP + 1);  // rise that the next one will follow too late
    pulses(1, 10);       // late edge: starts a run of one
    check("R5 spacing one past window", carrier_ok, 1'b0);
    pulses(N - 2, 10);
    check("R8 requalify partial", carrier_ok, 1'b0);
    pulses(1, 10);
    check("R8 requalify complete", carrier_ok, 1'b1);
  endtask

  task automatic t_gap_in_qualify();
    clear_state();
    pulses(N - 1, 10);
    ticks(GAP + 5);
    pulses(N - 1, 10);
    check("R6 gap cleared count", carrier_ok, 1'b0);
    pulses(1, 10);
    check("R6 fresh run completes", carrier_ok, 1'b1);
  endtask

  task automatic t_transmit();
    check("R7 precondition", carrier_ok, 1'b1);
    rts_n = 1'b0; ticks(1);
    check("R7 cleared next edge", carrier_ok, 1'b0);
    pulses(2 * N, 10);
    check("R10 no carrier while transmitting", carrier_ok, 1'b0);
    rts_n = 1'b1; ticks(1);
    pulses(N - 1, 10);
    check("R10 no leftover count", carrier_ok, 1'b0);
    pulses(1, 10);
    check("R8 requalify after transmit", carrier_ok, 1'b1);
  endtask

  task automatic t_level_held();
    clear_state();
    pulses(N - 2, 10);
    cmp_pulse = 1'b1; ticks(30);
    check("R9 held level is one edge", carrier_ok, 1'b0);
    cmp_pulse = 1'b0; ticks(5);
    pulses(1, 10);
    check("R9 next edge completes run", carrier_ok, 1'b1);
  endtask

  initial begin
    ticks(3);
    t_reset();
    t_qualify_latency();
    t_hold_boundary();
    t_late_edge();
    t_gap_in_qualify();
    t_transmit();
    t_level_held();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, carrier_ok=%0b expected completion", carrier_ok);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule